// File: doc/BRIEF.md
# Receive Stream Command Capture

This block gathers a receive stream command that software delivers as three separate register writes. The first write carries a command word, the second the whole-seconds part of a start time, and the third the sub-second tick part. The first two writes only load staging registers. The tick write completes the command: it combines the staged word, the staged seconds and its own data into one entry and places that entry in a small command queue. A downstream receive-control engine reads from this queue. Because the tick write is the only commit point, the engine never sees a command that is only partly written.

On the queue output the command word is already decoded. The block presents the start-immediately flag, the chain flag, the reload flag, the sample count and a 64-bit timestamp. It also derives a command kind: stop, continuous or counted. The consumer removes the head entry with a pop strobe.

A tick write that arrives while the queue is full is discarded and raises a sticky overflow flag. A write to a fourth register empties the queue and clears that flag.

Top module: `stream_cmd_capture`

## Requirements
- R1: The register window starts at BASE_ADDR (default 0x10). Offset 0 is the command word, offset 1 the seconds word, offset 2 the ticks word and offset 3 the clear register. Writes to any other address change neither the queue nor the overflow flag.
- R2: A write to the command or seconds register by itself never adds a queue entry.
- R3: The command word is decoded as follows: bit 31 gives cmd_now, bit 30 gives cmd_chain, bit 29 gives cmd_reload, and bits 28:0 give cmd_count.
- R4: cmd_time is {seconds word, ticks word}, with the seconds word in bits 63:32.
- R5: cmd_kind is 0 (stop) when chain is clear and the count is 0. It is 1 (continuous) when chain is set and the count is 1. It is 2 (counted) in every other case.
- R6: A ticks write to a queue that is not full adds one entry. That entry is visible (cmd_valid high) from the clock edge that takes the write. Entries leave in arrival order, and the queue holds DEPTH entries (default 8).
- R7: The staging registers keep their values after a commit, so a second ticks write reuses the last command word and seconds word.
- R8: A ticks write while the queue holds DEPTH entries is dropped and sets overflow. Fullness is judged before a pop in the same cycle. overflow stays set until a clear write or reset.
- R9: A write to the clear register empties the queue and clears overflow after one edge. The staging registers are left unchanged.
- R10: cmd_pop while the queue is empty has no effect. A pop and a ticks write in the same cycle on a non-empty, non-full queue both take effect.
- R11: After reset, cmd_valid and overflow are 0 and the staging registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| cmd_pop | input | 1 | Consumer removes the head entry |
| cmd_valid | output | 1 | Queue holds at least one command |
| cmd_now | output | 1 | Head: start immediately, ignore time |
| cmd_chain | output | 1 | Head: chain to the next command |
| cmd_reload | output | 1 | Head: reload flag |
| cmd_kind | output | 2 | Head: 0 stop, 1 continuous, 2 counted |
| cmd_count | output | 29 | Head: sample count |
| cmd_time | output | 64 | Head: {seconds, ticks} |
| overflow | output | 1 | Sticky: a commit was dropped on a full queue |

## Verification
Two pairs of events can land in the same cycle: a commit together with a consumer pop, and a commit together with a full queue. The bench drives a ticks write and cmd_pop on the same clock in three states: an empty queue (only the push happens), a partly filled queue (both happen, so the occupancy stays the same) and a full queue (the write is dropped, the pop still happens and overflow rises). A behavioural queue model in the bench is compared with the outputs on every clock, and each of these cases also has explicit checks of cmd_valid, the head fields and overflow.

// File: rtl/streamcmd_pkg.sv
package streamcmd_pkg;
   localparam int CNT_W  = 29;
   localparam int SEC_W  = 32;
   localparam int TICK_W = 32;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      KIND_STOP    = 2'd0,
      KIND_CONT    = 2'd1,
      KIND_COUNTED = 2'd2
   } cmd_kind_e;

   typedef struct packed {
      logic              start_now;
      logic              chain;
      logic              reload;
      cmd_kind_e         kind;
      logic [CNT_W-1:0]  count;
      logic [SEC_W-1:0]  secs;
      logic [TICK_W-1:0] ticks;
   } cmd_entry_t;

   function automatic cmd_kind_e classify(input logic chain, input logic [CNT_W-1:0] count);
      if (!chain && count == '0)
         return KIND_STOP;
      else if (chain && count == CNT_W'(1))
         return KIND_CONT;
      else
         return KIND_COUNTED;
   endfunction
endpackage

// File: rtl/scap_addr_decode.sv
module scap_addr_decode #(
   parameter int          ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit_cmd,
   output logic              hit_secs,
   output logic              hit_ticks,
   output logic              hit_clear
);
   localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(BASE_ADDR);
   localparam bit                ALIGNED = (BASE_ADDR % 4) == 0;

   if (ADDR_W < 3) begin : g_bad_width
      $error("scap_addr_decode: ADDR_W must be at least 3");
   end
   if (BASE_ADDR + 3 >= (64'd1 << ADDR_W)) begin : g_bad_base
      $error("scap_addr_decode: register window exceeds address space");
   end

   logic [1:0] sel;
   logic       in_win;

   if (ALIGNED) begin : g_aligned
      assign in_win = (wr_addr[ADDR_W-1:2] == BASE_V[ADDR_W-1:2]);
      assign sel    = wr_addr[1:0];
   end else begin : g_offset
      logic [ADDR_W-1:0] off;
      assign off    = wr_addr - BASE_V;
      assign in_win = (off < ADDR_W'(4));
      assign sel    = off[1:0];
   end

   assign hit_cmd   = wr_en && in_win && (sel == 2'd0);
   assign hit_secs  = wr_en && in_win && (sel == 2'd1);
   assign hit_ticks = wr_en && in_win && (sel == 2'd2);
   assign hit_clear = wr_en && in_win && (sel == 2'd3);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_cmd, hit_secs, hit_ticks, hit_clear})) else $error("AST_ONE_STROBE"); // R1
   AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !(hit_cmd || hit_secs || hit_ticks || hit_clear)) else $error("AST_STROBE_NEEDS_EN"); // R1
endmodule

// File: rtl/scap_stage.sv
module scap_stage
   import streamcmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              hit_cmd,
   input  logic              hit_secs,
   input  logic              hit_ticks,
   output logic              push_req,
   output cmd_entry_t        push_entry
);
   logic [WORD_W-1:0] cmd_word_q;
   logic [SEC_W-1:0]  secs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_word_q <= '0;
         secs_q     <= '0;
      end else begin
         if (hit_cmd)  cmd_word_q <= wr_data;
         if (hit_secs) secs_q     <= wr_data[SEC_W-1:0];
      end
   end

   always_comb begin
      push_entry.start_now = cmd_word_q[31];
      push_entry.chain     = cmd_word_q[30];
      push_entry.reload    = cmd_word_q[29];
      push_entry.count     = cmd_word_q[CNT_W-1:0];
      push_entry.kind      = classify(cmd_word_q[30], cmd_word_q[CNT_W-1:0]);
      push_entry.secs      = secs_q;
      push_entry.ticks     = wr_data[TICK_W-1:0];
   end

   assign push_req = hit_ticks;

   AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_cmd && !hit_secs) |=> ($stable(cmd_word_q) && $stable(secs_q))) else $error("AST_STAGE_HOLDS"); // R7
endmodule

// File: rtl/scap_fifo.sv
module scap_fifo
   import streamcmd_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       push_req,
   input  cmd_entry_t din,
   input  logic       pop_req,
   output cmd_entry_t dout,
   output logic       empty,
   output logic       full,
   output logic       dropped
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  LVL_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("scap_fifo: DEPTH must be in 2..64");
   end

   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
   logic [LVL_W-1:0] level_q;
   logic             do_push, do_pop;
   cmd_entry_t       slots [DEPTH];

   assign empty   = (level_q == '0);
   assign full    = (level_q == LVL_W'(DEPTH));
   assign do_push = push_req && !full && !clr;
   assign do_pop  = pop_req && !empty && !clr;
   assign dropped = push_req && full && !clr;

   if (POW2) begin : g_wrap_natural
      assign wr_ptr_nx = wr_ptr_q + PTR_W'(1);
      assign rd_ptr_nx = rd_ptr_q + PTR_W'(1);
   end else begin : g_wrap_compare
      assign wr_ptr_nx = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
      assign rd_ptr_nx = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
      cmd_entry_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (do_push && wr_ptr_q == IDX)
            slot_q <= din;
      end
      assign slots[g] = slot_q;
   end

   assign dout = slots[rd_ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_nx;
         if (do_pop)  rd_ptr_q <= rd_ptr_nx;
         level_q <= level_q + LVL_W'(do_push) - LVL_W'(do_pop);
      end
   end

   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_W'(DEPTH)) else $error("AST_LEVEL_RANGE"); // R6
   AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !full && !clr) |=> !empty) else $error("AST_PUSH_SHOWS"); // R6
   AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !clr && !pop_req) |=> full) else $error("AST_DROP_KEEPS_FULL"); // R8
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty) else $error("AST_CLEAR_EMPTIES"); // R9
   AST_POP_EMPTY_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_req && !push_req && !clr) |=> empty) else $error("AST_POP_EMPTY_NOOP"); // R10
endmodule

// File: rtl/stream_cmd_capture.sv
module stream_cmd_capture
   import streamcmd_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h10,
   parameter int          DEPTH     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              cmd_pop,
   output logic              cmd_valid,
   output logic              cmd_now,
   output logic              cmd_chain,
   output logic              cmd_reload,
   output logic [1:0]        cmd_kind,
   output logic [28:0]       cmd_count,
   output logic [63:0]       cmd_time,
   output logic              overflow
);
   logic       hit_cmd, hit_secs, hit_ticks, hit_clear;
   logic       push_req, dropped, q_empty, q_full;
   cmd_entry_t push_entry, head;
   logic       ovf_q;

   scap_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .hit_cmd(hit_cmd), .hit_secs(hit_secs), .hit_ticks(hit_ticks), .hit_clear(hit_clear)
   );

   scap_stage u_stage (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
      .hit_cmd(hit_cmd), .hit_secs(hit_secs), .hit_ticks(hit_ticks),
      .push_req(push_req), .push_entry(push_entry)
   );

   scap_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(hit_clear),
      .push_req(push_req), .din(push_entry), .pop_req(cmd_pop),
      .dout(head), .empty(q_empty), .full(q_full), .dropped(dropped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovf_q <= 1'b0;
      else if (hit_clear) ovf_q <= 1'b0;
      else if (dropped)   ovf_q <= 1'b1;
   end

   assign overflow   = ovf_q;
   assign cmd_valid  = !q_empty;
   assign cmd_now    = head.start_now;
   assign cmd_chain  = head.chain;
   assign cmd_reload = head.reload;
   assign cmd_kind   = head.kind;
   assign cmd_count  = head.count;
   assign cmd_time   = {head.secs, head.ticks};

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !hit_clear) |=> overflow) else $error("AST_OVF_STICKY"); // R8
   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(hit_ticks && q_full)) else $error("AST_OVF_CAUSE"); // R8
   AST_CLEAR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clear |=> !overflow) else $error("AST_CLEAR_OVF"); // R9
   AST_STOP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'd0) |-> (!cmd_chain && cmd_count == '0)) else $error("AST_STOP_SHAPE"); // R5
endmodule

// File: tb/stream_cmd_capture_tb.sv
module stream_cmd_capture_tb;
   localparam int BASE = 'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        cmd_pop = 1'b0;
   logic        cmd_valid, cmd_now, cmd_chain, cmd_reload, overflow;
   logic [1:0]  cmd_kind;
   logic [28:0] cmd_count;
   logic [63:0] cmd_time;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;

   always #2 clk = ~clk;

   stream_cmd_capture u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmd_pop(cmd_pop), .cmd_valid(cmd_valid), .cmd_now(cmd_now), .cmd_chain(cmd_chain),
      .cmd_reload(cmd_reload), .cmd_kind(cmd_kind), .cmd_count(cmd_count),
      .cmd_time(cmd_time), .overflow(overflow)
   );

   // reference model
   logic [95:0] mq[$];   // {cmd word, secs, ticks}
   logic [31:0] m_cmd = '0, m_secs = '0;
   bit          m_ovf = 0;

   function automatic int ref_kind(logic [31:0] w);
      if (!w[30] && w[28:0] == 0) return 0;
      if (w[30] && w[28:0] == 1) return 1;
      return 2;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_cmd = '0; m_secs = '0; m_ovf = 0;
      end else begin
         bit full, popok, push, clr;
         full = (mq.size() == 8);
         popok = cmd_pop && mq.size() > 0;
         push = 0; clr = 0;
         if (wr_en) begin
            case (int'(wr_addr) - BASE)
               0: m_cmd = wr_data;
               1: m_secs = wr_data;
               2: if (full) m_ovf = 1; else push = 1;
               3: clr = 1;
               default: ;
            endcase
         end
         if (clr) begin
            mq.delete(); m_ovf = 0;
         end else begin
            if (popok) void'(mq.pop_front());
            if (push) mq.push_back({m_cmd, m_secs, wr_data});
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 cmd_valid vs model", 64'(cmd_valid), 64'(mq.size() > 0));
         check("R8 overflow vs model", 64'(overflow), 64'(m_ovf));
         if (mq.size() > 0) begin
            logic [31:0] w;
            w = mq[0][95:64];
            check("R3 flags vs model", {61'd0, cmd_now, cmd_chain, cmd_reload}, {61'd0, w[31], w[30], w[29]});
            check("R3 count vs model", 64'(cmd_count), 64'(w[28:0]));
            check("R4 time vs model", cmd_time, mq[0][63:0]);
            check("R5 kind vs model", 64'(cmd_kind), 64'(ref_kind(w)));
         end
      end
   end

   task automatic step(bit en, int a, logic [31:0] d, bit p);
      @(negedge clk);
      wr_en = en; wr_addr = 8'(a); wr_data = d; cmd_pop = p;
   endtask
   task automatic idle();
      step(0, 0, 0, 0);
   endtask
   task automatic wr(int off, logic [31:0] d);
      step(1, BASE + off, d, 0);
      idle();
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<20000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset cmd_valid", 64'(cmd_valid), 0);
      check("R11 reset overflow", 64'(overflow), 0);

      // R11: staging is zero after reset, ticks-only write yields stop with secs 0
      wr(2, 32'h0000_0077);
      check("R11 staged zero kind", 64'(cmd_kind), 0);
      check("R11 staged zero time", cmd_time, 64'h0000_0000_0000_0077);
      step(0, 0, 0, 1); idle();
      check("R10 pop emptied", 64'(cmd_valid), 0);

      // R1: out-of-window addresses ignored
      step(1, BASE + 4, 32'h1234, 0); step(1, BASE - 1, 32'h5678, 0); step(1, BASE + 6, 32'h9, 0); idle();
      check("R1 stray writes no entry", 64'(cmd_valid), 0);

      // R2: cmd and secs alone do not commit
      wr(0, 32'hA000_0005);
      wr(1, 32'h0000_00C8);
      check("R2 no commit before ticks", 64'(cmd_valid), 0);

      // R6/R3/R4/R5 main commit
      wr(2, 32'h0001_0000);
      check("R6 valid after ticks", 64'(cmd_valid), 1);
      check("R3 now", 64'(cmd_now), 1);
      check("R3 chain", 64'(cmd_chain), 0);
      check("R3 reload", 64'(cmd_reload), 1);
      check("R3 count", 64'(cmd_count), 5);
      check("R4 time", cmd_time, 64'h0000_00C8_0001_0000);
      check("R5 counted kind", 64'(cmd_kind), 2);

      // R7: second ticks reuses staging
      wr(2, 32'h0000_0042);
      step(0, 0, 0, 1); idle();
      check("R7 reused secs", cmd_time, 64'h0000_00C8_0000_0042);
      check("R7 reused count", 64'(cmd_count), 5);
      step(0, 0, 0, 1); idle();

      // R5 kinds
      wr(0, 32'h4000_0001); wr(2, 1);
      check("R5 continuous", 64'(cmd_kind), 1);
      step(0, 0, 0, 1); idle();
      wr(0, 32'h0000_0000); wr(2, 2);
      check("R5 stop", 64'(cmd_kind), 0);
      step(0, 0, 0, 1); idle();
      wr(0, 32'h0000_0001); wr(2, 3);
      check("R5 count1 no chain counted", 64'(cmd_kind), 2);
      step(0, 0, 0, 1); idle();
      wr(0, 32'h4000_0000); wr(2, 4);
      check("R5 chain count0 counted", 64'(cmd_kind), 2);
      step(0, 0, 0, 1); idle();
      wr(0, 32'h5FFF_FFFF); wr(2, 5);
      check("R3 max count", 64'(cmd_count), 64'h1FFF_FFFF);
      step(0, 0, 0, 1); idle();

      // R10: pop on empty, then push+pop same cycle on empty and non-empty
      step(0, 0, 0, 1); idle();
      check("R10 pop empty", 64'(cmd_valid), 0);
      wr(0, 32'h0000_0010);
      step(1, BASE + 2, 32'hAA, 1); idle();
      check("R10 push with pop on empty", 64'(cmd_valid), 1);
      check("R10 push with pop on empty head", cmd_time[31:0], 32'hAA);
      step(1, BASE + 2, 32'hBB, 1); idle();
      check("R10 push+pop head advanced", cmd_time[31:0], 32'hBB);
      step(0, 0, 0, 1); idle();
      check("R10 single entry left", 64'(cmd_valid), 0);

      // R8: fill, then drop with pop in same cycle
      for (int i = 0; i < 8; i++) wr(2, 32'(100 + i));
      check("R8 no overflow at full", 64'(overflow), 0);
      step(1, BASE + 2, 32'hDEAD, 1); idle();
      check("R8 overflow on full commit", 64'(overflow), 1);
      check("R6 order head", cmd_time[31:0], 32'd101);
      wr(2, 32'd200);
      check("R8 overflow sticky", 64'(overflow), 1);
      for (int i = 0; i < 7; i++) begin
         step(0, 0, 0, 1); idle();
      end
      check("R6 fifo tail", cmd_time[31:0], 32'd200);

      // R9: clear
      wr(3, 0);
      check("R9 clear empties", 64'(cmd_valid), 0);
      check("R9 clear drops overflow", 64'(overflow), 0);
      wr(2, 32'h77);
      check("R9 staging kept count", 64'(cmd_count), 64'h10);
      check("R9 staging kept secs", cmd_time, 64'h0000_00C8_0000_0077);

      repeat (3) idle();
      finish_run();
   end
endmodule